// File: doc/BRIEF.md
# Linear Ramped-FSK Frequency Sweeper

This block produces a 48-bit frequency tuning word that glides in a straight line between a low word and a high word. A one-bit keying input chooses the target. When the key is high, the word climbs toward the high word. When the key is low, it falls back toward the low word. Each strobe from an external ramp-rate timer moves the word by one step of programmable size. The word never passes its target. Once it sits on the target, a completion flag tells the timer to stop, and the word holds for as long as the key stays unchanged.

Internally the block keeps an offset above the latched low word. The low word, the high word and the step size are sampled only when a strobe or a clear arrives. Software may therefore rewrite them during a glide and get a piecewise, non-linear sweep. A clear control zeroes the offset.

The current frequency word also drives a 48-bit phase accumulator. The phase accumulator advances by that word on every clock.

Top module: `rfsk_sweep`

## Requirements
- R1: While reset is asserted, `freq_o` and `phase_o` are zero and `done_o` is 1, because the key register is low and the offset is zero.
- R2: Without a strobe or a clear, `freq_o` keeps its value on the next clock.
- R3: A strobe with `fsk_i`=1 raises `freq_o` by `step_i` on that edge. If the result would exceed the high word, `freq_o` lands exactly on the high word.
- R4: A strobe with `fsk_i`=0 lowers `freq_o` by `step_i` on that edge. If the result would fall below the low word, `freq_o` lands exactly on the low word.
- R5: `done_o` is 1 exactly when the registered key is 1 and `freq_o` equals the latched high word, or when the registered key is 0 and `freq_o` equals the latched low word. While `done_o` is 1, with no clear and an unchanged key, it stays 1.
- R6: The key is registered once. After `fsk_i` changes, `done_o` reflects the new target from the following clock edge.
- R7: A clear has priority over a strobe. After the edge, `freq_o` equals the `f_lo_i` present at that edge.
- R8: New values on `f_lo_i`, `f_hi_i` or `step_i` take effect only at the next strobe or clear.
- R9: On every clock, `phase_o` becomes its previous value plus the previous `freq_o`, modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| f_lo_i | input | 48 | Low tuning word (must not exceed the high word) |
| f_hi_i | input | 48 | High tuning word |
| step_i | input | 48 | Step added or removed per strobe |
| tick_i | input | 1 | One-cycle ramp-rate strobe |
| fsk_i | input | 1 | Key level: 1 targets the high word, 0 the low word |
| clr_acc_i | input | 1 | Zero the offset and latch the tuning words |
| freq_o | output | 48 | Current frequency word |
| done_o | output | 1 | Target reached; stop the ramp-rate timer |
| phase_o | output | 48 | Phase accumulator value |

## Verification
Some properties are checked on every cycle:
- the word holds between strobes;
- the word stays inside the latched low and high bounds;
- a clear lands the word on the low word;
- completion persists while the key dwells;
- the phase advances by the previous frequency word.

The bench scenarios cover what needs exact arithmetic over many steps: the clamp landing on each target and the one-cycle drop of `done_o` after a key change. They also cover mid-sweep changes of step size and bounds that wait for the next strobe, and phase wrap-around at 2^48.

// File: rtl/rfsk_pkg.sv
package rfsk_pkg;
  localparam int unsigned RFSK_FW = 48;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_UP    = 2'd1,
    OP_DOWN  = 2'd2,
    OP_CLEAR = 2'd3
  } rfsk_op_e;
endpackage

// File: rtl/rfsk_rst_sync.sv
module rfsk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/rfsk_step_unit.sv
module rfsk_step_unit
  import rfsk_pkg::*;
#(
  parameter int unsigned FW = RFSK_FW
) (
  input  rfsk_op_e        op_i,
  input  logic [FW-1:0]   off_i,
  input  logic [FW-1:0]   step_i,
  input  logic [FW-1:0]   span_i,
  output logic [FW-1:0]   off_o
);
  logic [FW:0] sum_w;

  always_comb begin
    sum_w = {1'b0, off_i} + {1'b0, step_i};
    unique case (op_i)
      OP_UP:    off_o = (sum_w >= {1'b0, span_i}) ? span_i : sum_w[FW-1:0];
      OP_DOWN:  off_o = (step_i >= off_i) ? '0 : (off_i - step_i);
      OP_CLEAR: off_o = '0;
      default:  off_o = off_i;
    endcase
  end
endmodule

// File: rtl/rfsk_ramp_ctrl.sv
module rfsk_ramp_ctrl
  import rfsk_pkg::*;
#(
  parameter int unsigned FW = RFSK_FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] f_lo_i,
  input  logic [FW-1:0] f_hi_i,
  input  logic [FW-1:0] step_i,
  input  logic          tick_i,
  input  logic          fsk_i,
  input  logic          clr_i,
  output logic [FW-1:0] freq_o,
  output logic [FW-1:0] lo_o,
  output logic [FW-1:0] hi_o,
  output logic          key_o,
  output logic          done_o
);
  rfsk_op_e      op_d;
  logic          ld_en;
  logic [FW-1:0] span_d;
  logic [FW-1:0] off_d, off_q;
  logic [FW-1:0] lo_q, hi_q;
  logic          key_q;

  always_comb begin
    if (clr_i)       op_d = OP_CLEAR;
    else if (tick_i) op_d = fsk_i ? OP_UP : OP_DOWN;
    else             op_d = OP_HOLD;
    ld_en  = (op_d != OP_HOLD);
    span_d = f_hi_i - f_lo_i;
  end

  rfsk_step_unit #(.FW(FW)) u_step (
    .op_i   (op_d),
    .off_i  (off_q),
    .step_i (step_i),
    .span_i (span_d),
    .off_o  (off_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (ld_en) begin
      off_q <= off_d;
      lo_q  <= f_lo_i;
      hi_q  <= f_hi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= 1'b0;
    else         key_q <= fsk_i;
  end

  assign freq_o = lo_q + off_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign key_o  = key_q;
  assign done_o = key_q ? (freq_o == hi_q) : (off_q == '0);
endmodule

// File: rtl/rfsk_phase_acc.sv
module rfsk_phase_acc
  import rfsk_pkg::*;
#(
  parameter int unsigned FW = RFSK_FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] incr_i,
  output logic [FW-1:0] phase_o
);
  logic [FW-1:0] phase_d, phase_q;

  always_comb phase_d = phase_q + incr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/rfsk_sweep.sv
module rfsk_sweep
  import rfsk_pkg::*;
#(
  parameter int unsigned FW = RFSK_FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] f_lo_i,
  input  logic [FW-1:0] f_hi_i,
  input  logic [FW-1:0] step_i,
  input  logic          tick_i,
  input  logic          fsk_i,
  input  logic          clr_acc_i,
  output logic [FW-1:0] freq_o,
  output logic          done_o,
  output logic [FW-1:0] phase_o
);
  logic          rst_n_s;
  logic          rst_n_int;
  logic [FW-1:0] lo_lat, hi_lat;
  logic          key_lat;

  rfsk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  // assertion is immediate, release waits for the synchronizer
  assign rst_n_int = rst_ni & rst_n_s;

  rfsk_ramp_ctrl #(.FW(FW)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .f_lo_i (f_lo_i),
    .f_hi_i (f_hi_i),
    .step_i (step_i),
    .tick_i (tick_i),
    .fsk_i  (fsk_i),
    .clr_i  (clr_acc_i),
    .freq_o (freq_o),
    .lo_o   (lo_lat),
    .hi_o   (hi_lat),
    .key_o  (key_lat),
    .done_o (done_o)
  );

  rfsk_phase_acc #(.FW(FW)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .incr_i  (freq_o),
    .phase_o (phase_o)
  );
endmodule

// File: rtl/rfsk_sweep_chk.sv
module rfsk_sweep_chk #(
  parameter int unsigned FW = 48
) (
  input logic          clk_i,
  input logic          rst_n_int,
  input logic [FW-1:0] f_lo_i,
  input logic          tick_i,
  input logic          fsk_i,
  input logic          clr_acc_i,
  input logic [FW-1:0] freq_o,
  input logic          done_o,
  input logic [FW-1:0] phase_o,
  input logic [FW-1:0] lo_lat,
  input logic [FW-1:0] hi_lat,
  input logic          key_lat
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (!tick_i && !clr_acc_i) |=> $stable(freq_o));

  p_ceiling_r3: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    freq_o <= hi_lat);

  p_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    freq_o >= lo_lat);

  p_dwell_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (done_o && !clr_acc_i && (fsk_i == key_lat)) |=> done_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    clr_acc_i |=> (freq_o == $past(f_lo_i)));

  p_phase_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    1'b1 |=> (phase_o == $past(phase_o) + $past(freq_o)));
endmodule

bind rfsk_sweep rfsk_sweep_chk #(.FW(FW)) u_chk (
  .clk_i     (clk_i),
  .rst_n_int (rst_n_int),
  .f_lo_i    (f_lo_i),
  .tick_i    (tick_i),
  .fsk_i     (fsk_i),
  .clr_acc_i (clr_acc_i),
  .freq_o    (freq_o),
  .done_o    (done_o),
  .phase_o   (phase_o),
  .lo_lat    (lo_lat),
  .hi_lat    (hi_lat),
  .key_lat   (key_lat)
);

// File: tb/rfsk_sweep_tb_top.sv
module rfsk_sweep_tb_top;
  localparam int FW = 48;
  // row layout: clr, tick, fsk, lo, hi, step, exp_freq, exp_done, req
  localparam int VW = 3 + 4*FW + 1 + 4;
  localparam int NV = 16;

  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b100, 48'd100, 48'd130, 48'd7,  48'd100, 1'b1, 4'd7}, // R7 clear
    {3'b010, 48'd100, 48'd130, 48'd7,  48'd100, 1'b1, 4'd4}, // R4 floor
    {3'b001, 48'd100, 48'd130, 48'd7,  48'd100, 1'b0, 4'd6}, // R6 key up
    {3'b011, 48'd100, 48'd130, 48'd7,  48'd107, 1'b0, 4'd3}, // R3
    {3'b001, 48'd100, 48'd130, 48'd7,  48'd107, 1'b0, 4'd2}, // R2 hold
    {3'b011, 48'd100, 48'd130, 48'd7,  48'd114, 1'b0, 4'd3},
    {3'b011, 48'd100, 48'd130, 48'd7,  48'd121, 1'b0, 4'd3},
    {3'b011, 48'd100, 48'd130, 48'd7,  48'd128, 1'b0, 4'd3},
    {3'b011, 48'd100, 48'd130, 48'd7,  48'd130, 1'b1, 4'd3}, // R3 clamp
    {3'b011, 48'd100, 48'd130, 48'd7,  48'd130, 1'b1, 4'd5}, // R5 dwell
    {3'b000, 48'd100, 48'd130, 48'd7,  48'd130, 1'b0, 4'd6}, // R6 key down
    {3'b010, 48'd100, 48'd130, 48'd20, 48'd110, 1'b0, 4'd8}, // R8 step
    {3'b010, 48'd100, 48'd130, 48'd20, 48'd100, 1'b1, 4'd4}, // R4 clamp
    {3'b000, 48'd50,  48'd130, 48'd20, 48'd100, 1'b1, 4'd8}, // R8 lo wait
    {3'b010, 48'd50,  48'd130, 48'd20, 48'd50,  1'b1, 4'd8}, // R8 lo taken
    {3'b111, 48'd50,  48'd130, 48'd20, 48'd50,  1'b0, 4'd7}  // R7 priority
  };

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [FW-1:0] f_lo_i, f_hi_i, step_i;
  logic          tick_i, fsk_i, clr_acc_i;
  logic [FW-1:0] freq_o, phase_o;
  logic          done_o;
  int            n_checks = 0;
  int            n_errors = 0;

  always #4 clk_i = ~clk_i;

  rfsk_sweep dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .f_lo_i(f_lo_i), .f_hi_i(f_hi_i),
    .step_i(step_i), .tick_i(tick_i), .fsk_i(fsk_i), .clr_acc_i(clr_acc_i),
    .freq_o(freq_o), .done_o(done_o), .phase_o(phase_o)
  );

  task automatic check(input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic t, input logic k,
                       input logic [FW-1:0] lo, input logic [FW-1:0] hi,
                       input logic [FW-1:0] st);
    clr_acc_i = c; tick_i = t; fsk_i = k;
    f_lo_i = lo; f_hi_i = hi; step_i = st;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [FW-1:0] p0;
    rst_ni = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0, '0, '0);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 freq", freq_o, '0);
    check("R1 phase", phase_o, '0);
    check("R1 done", {47'd0, done_o}, 48'd1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      drive(v[VW-1], v[VW-2], v[VW-3], v[VW-4 -: FW], v[VW-4-FW -: FW],
            v[VW-4-2*FW -: FW]);
      @(posedge clk_i); #1;
      tag = $sformatf("R%0d row%0d", v[3:0], i);
      check({tag, " freq"}, freq_o, v[VW-4-3*FW -: FW]);
      check({tag, " done"}, {47'd0, done_o}, {47'd0, v[4]});
      @(negedge clk_i);
    end

    // R9 phase advance by a small word
    drive(1'b1, 1'b0, 1'b0, 48'd5, 48'd5, 48'd1);
    @(posedge clk_i); #1;
    check("R7 clear to 5", freq_o, 48'd5);
    p0 = phase_o;
    @(negedge clk_i); clr_acc_i = 1'b0;
    repeat (4) @(posedge clk_i); #1;
    check("R9 phase +20", phase_o, p0 + 48'd20);

    // R9 wrap-around with an all-ones word
    @(negedge clk_i);
    drive(1'b1, 1'b0, 1'b0, {FW{1'b1}}, {FW{1'b1}}, 48'd1);
    @(posedge clk_i); #1;
    p0 = phase_o;
    @(negedge clk_i); clr_acc_i = 1'b0;
    repeat (3) @(posedge clk_i); #1;
    check("R9 wrap", phase_o, p0 - 48'd3);

    // R1 asynchronous reset mid-run
    @(negedge clk_i); #1;
    rst_ni = 1'b0;
    #1;
    check("R1 async freq", freq_o, '0);
    check("R1 async phase", phase_o, '0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule